// File: doc/BRIEF.md
# IrDA pulse width generator

This block sits after a serial transmitter and converts its bit stream into infrared-style pulses. Each bit boundary is marked by a one-cycle bit-start strobe that comes with the bit value. A zero bit produces one high pulse on the output. A one bit leaves the output low.

A mode input selects how long each pulse lasts. In relative mode the pulse lasts three ticks of the 16x oversampling clock enable, which is 3/16 of a bit period at any baud rate. In fixed mode an 8-bit down-timer, clocked by the module clock, sets the width. Software loads the timer's width value so that the pulse matches the 3/16 width at 115.2 kbit/s (about 1.627 µs), whatever baud rate is in use. The mode and the width value are captured at each strobe.

Top module: `irda_pw_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, pulse_o is low.
- R2: A bit-start strobe with bit value 0 drives pulse_o high from the next clock cycle, in either mode.
- R3: A bit-start strobe with bit value 1 drives pulse_o low from the next clock cycle, even if a pulse is in progress.
- R4: In relative mode (mode input 0), pulse_o falls in the cycle after the clock edge that samples the third 16x tick after the strobe. A tick in the same cycle as the strobe does not count.
- R5: In fixed mode (mode input 1), pulse_o stays high for exactly N+1 clock cycles, where N is the 8-bit width value read as unsigned. N = 0 gives one cycle and N = 255 gives 256 cycles.
- R6: In fixed mode the 16x tick has no effect on the length of the pulse.
- R7: The mode and the width value are sampled only at a zero-bit strobe. Changing either while a pulse is active has no effect on that pulse.
- R8: A zero-bit strobe during an active pulse restarts the width measurement from that strobe, using the mode and width present at that strobe.
- R9: pulse_o rises only in the cycle after a zero-bit strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x oversampling clock enable, one cycle wide |
| bit_start_i | input | 1 | Strobe marking the start of a transmitted bit |
| bit_val_i | input | 1 | Value of the bit that starts with the strobe |
| fixed_mode_i | input | 1 | 0: width is 3/16 bit period; 1: width set by the timer |
| width_i | input | 8 | Fixed-mode width value N, giving N+1 cycles |
| pulse_o | output | 1 | Pulse output, high while a pulse is active |

## Verification
A strobe shows on pulse_o one clock edge later. The end of a relative-mode pulse shows one edge after the edge that samples the third counted tick. The end of a fixed-mode pulse shows N+1 edges after the strobe edge. The bench's reference model applies these same latencies edge by edge. Inputs change on the falling edge and pulse_o is compared with the model on the falling edge, so each result is read in the first half-cycle in which it is due.

// File: rtl/irda_pw_pkg.sv
package irda_pw_pkg;
  typedef enum logic {
    PW_REL   = 1'b0,
    PW_FIXED = 1'b1
  } pw_mode_e;
endpackage

// File: rtl/irda_pw_load.sv
module irda_pw_load #(
  parameter int WIDTH_W   = 8,
  parameter int REL_TICKS = 3,
  parameter int CNT_W     = 8
) (
  input  irda_pw_pkg::pw_mode_e mode_i,
  input  logic [WIDTH_W-1:0]    width_i,
  output logic [CNT_W-1:0]      load_o
);
  // counter expires on the step that finds it at zero, so load count-1
  localparam logic [CNT_W-1:0] REL_LOAD = CNT_W'(REL_TICKS - 1);

  always_comb begin
    if (mode_i == irda_pw_pkg::PW_FIXED) load_o = CNT_W'(width_i);
    else                                 load_o = REL_LOAD;
  end
endmodule

// File: rtl/irda_pw_timer.sv
module irda_pw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (step_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = step_i && (cnt_q == '0) && !load_i;
endmodule

// File: rtl/irda_pw_gen.sv
module irda_pw_gen #(
  parameter int WIDTH_W   = 8,
  parameter int REL_TICKS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick16_i,
  input  logic               bit_start_i,
  input  logic               bit_val_i,
  input  logic               fixed_mode_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o
);
  import irda_pw_pkg::*;

  localparam int REL_W = (REL_TICKS > 1) ? $clog2(REL_TICKS) : 1;
  localparam int CNT_W = (WIDTH_W > REL_W) ? WIDTH_W : REL_W;

  pw_mode_e         mode_in, mode_q;
  logic             active_q, start_zero, step, expire;
  logic [CNT_W-1:0] load_val;

  assign mode_in    = fixed_mode_i ? PW_FIXED : PW_REL;
  assign start_zero = bit_start_i && !bit_val_i;

  irda_pw_load #(
    .WIDTH_W  (WIDTH_W),
    .REL_TICKS(REL_TICKS),
    .CNT_W    (CNT_W)
  ) u_load (
    .mode_i (mode_in),
    .width_i(width_i),
    .load_o (load_val)
  );

  // fixed mode counts module clocks, relative mode counts 16x ticks
  assign step = active_q && ((mode_q == PW_FIXED) || tick16_i);

  irda_pw_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_zero),
    .load_val_i(load_val),
    .step_i    (step),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= PW_REL;
    end else begin
      if (start_zero) mode_q <= mode_in;
      if (bit_start_i)  active_q <= !bit_val_i;
      else if (expire)  active_q <= 1'b0;
    end
  end

  assign pulse_o = active_q;
endmodule

// File: rtl/irda_pw_gen_chk.sv
module irda_pw_gen_chk #(
  parameter int WIDTH_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick16_i,
  input logic               bit_start_i,
  input logic               bit_val_i,
  input logic               fixed_mode_i,
  input logic [WIDTH_W-1:0] width_i,
  input logic               pulse_o
);
  logic fixed_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        fixed_seen_q <= 1'b0;
    else if (bit_start_i && !bit_val_i) fixed_seen_q <= fixed_mode_i;
  end

  a_r1_low_in_reset: assert property (@(posedge clk_i) !rst_ni |=> !pulse_o);

  a_r2_zero_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_i && !bit_val_i |=> pulse_o);

  a_r3_one_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_i && bit_val_i |=> !pulse_o);

  a_r4_rel_holds_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && !fixed_seen_q && !tick16_i && !bit_start_i |=> pulse_o);

  a_r5_fixed_zero_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_i && !bit_val_i && fixed_mode_i && width_i == '0 ##1 !bit_start_i
    |=> !pulse_o);

  a_r9_rise_only_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o && !(bit_start_i && !bit_val_i) |=> !pulse_o);
endmodule

bind irda_pw_gen irda_pw_gen_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick16_i    (tick16_i),
  .bit_start_i (bit_start_i),
  .bit_val_i   (bit_val_i),
  .fixed_mode_i(fixed_mode_i),
  .width_i     (width_i),
  .pulse_o     (pulse_o)
);

// File: tb/irda_pw_gen_test.sv
`timescale 1ns/1ps
module irda_pw_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bstart = 1'b0;
  logic       bval = 1'b1;
  logic       fmode = 1'b0;
  logic [7:0] width = 8'd0;
  logic       pulse;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  int  tick_per = 4;
  int  tick_ph = 0;
  bit  tick_en = 1'b0;

  // reference model state
  bit  m_pulse = 1'b0;
  bit  m_fixed = 1'b0;
  int  m_w = 0;
  int  m_ticks = 0;
  int  m_cyc = 0;

  always #2 clk = ~clk;

  irda_pw_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .bit_start_i(bstart),
    .bit_val_i(bval), .fixed_mode_i(fmode), .width_i(width), .pulse_o(pulse)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pulse = 1'b0;
    end else if (bstart) begin
      m_pulse = !bval;
      if (!bval) begin
        m_fixed = fmode; m_w = width; m_ticks = 0; m_cyc = 0;
      end
    end else if (m_pulse) begin
      if (m_fixed) begin
        m_cyc++;
        if (m_cyc > m_w) m_pulse = 1'b0;   // R5: width+1 cycles high
      end else if (tick) begin
        m_ticks++;
        if (m_ticks == 3) m_pulse = 1'b0;  // R4: third counted tick
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      compared++;
      if (pulse !== m_pulse) begin
        mismatched++;
        $display("FAIL %s cycle %0d: pulse_o actual %0b expected %0b",
                 cur_req, cycles, pulse, m_pulse);
      end
    end
    if (tick_en) begin
      tick_ph++;
      tick = (tick_ph % tick_per) == 0;
    end else tick = 1'b0;
  end

  task automatic strobe(input bit v);
    @(negedge clk);
    bstart = 1'b1; bval = v;
    @(negedge clk);
    bstart = 1'b0; bval = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: output low in reset
    compared++;
    if (pulse !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: pulse_o actual %0b expected 0 in reset", pulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (pulse !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: pulse_o actual %0b expected 0 after reset", pulse);
    end

    tick_en = 1'b1;
    cur_req = "R2/R4";
    fmode = 1'b0;
    strobe(1'b0); idle(20);
    tick_per = 3; strobe(1'b0); idle(15);
    tick_per = 1; strobe(1'b0); idle(8);     // tick in strobe cycle not counted
    tick_per = 5;

    cur_req = "R3";
    strobe(1'b1); idle(10);
    strobe(1'b0); idle(2); strobe(1'b1); idle(10);

    cur_req = "R5/R6";
    fmode = 1'b1;
    width = 8'd0;   strobe(1'b0); idle(6);
    width = 8'd5;   strobe(1'b0); idle(10);
    tick_en = 1'b0;
    width = 8'd7;   strobe(1'b0); idle(12);
    tick_en = 1'b1; tick_per = 1;
    width = 8'd255; strobe(1'b0); idle(270);
    tick_per = 4;

    cur_req = "R7";
    width = 8'd10; strobe(1'b0);
    width = 8'd1; fmode = 1'b0; idle(20);
    fmode = 1'b0; strobe(1'b0);
    fmode = 1'b1; width = 8'd200; idle(25);

    cur_req = "R8";
    fmode = 1'b1; width = 8'd8;
    strobe(1'b0); idle(3); strobe(1'b0); idle(15);
    fmode = 1'b0; strobe(1'b0); idle(5);
    fmode = 1'b1; width = 8'd2; strobe(1'b0); idle(8);

    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      tick_per = 1 + ($urandom % 6);
      fmode = $urandom % 2;
      width = 8'($urandom % 24);
      if (($urandom % 3) == 0) strobe(1'($urandom % 2));
      else idle(1 + ($urandom % 6));
    end
    idle(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule